// File: doc/BRIEF.md
# Sequential Shift-Add Mantissa Multiplier

This block multiplies two unsigned floating-point mantissas over several clock cycles. Each mantissa is `NWORDS` words of `WORD_W` bits. The unit bit (value 1.0) is at position `LEAD`, and the `NG` lowest bits are guard positions. Word 0 is bits `[WORD_W-1:0]`, the least significant word. An operation is launched with a one-cycle `start`, which captures both mantissas and both exponents. The block then scans the multiplier from its least significant bit upward. For each bit it shifts a working accumulator right by one, ORs the bit that falls off into a sticky flag, and adds the multiplicand when the multiplier bit is 1.

A multiplier word that is entirely zero, other than the top word, takes one cycle instead of one cycle per bit. In that cycle the accumulator drops its low word into the sticky flag and moves down a whole word. While no add has yet happened, that move is suppressed, because the accumulator is still zero. Scanning of word 0 begins at bit `NG`, since the guard bits of a normalised multiplier are zero. Scanning of the top word ends at its highest set bit.

A last cycle brings a product in [2, 4) back into [1, 2) by one extra right shift. That cycle also registers the mantissa, the exponent sum and the sticky flag, and a one-cycle `done` pulse marks the new result. Rounding, signs and special operands are handled elsewhere.

Top module: `mant_shift_mul`

## Requirements
- R1: Inputs are normalised: bit `LEAD` is set, bits above it are zero, and the multiplier's low `NG` bits are zero. Under these inputs, when no normalisation shift is needed, `prod_mant` equals floor(X*Y / 2^LEAD).
- R2: `prod_sticky` is 1 exactly when at least one bit discarded from the full product X*Y is 1. Once the sticky flag is set during an operation, it stays set.
- R3: When bit `LEAD+1` of the raw product is set, the result is shifted right once more and the bit shifted out joins the sticky flag. After this shift, bit `LEAD+1` of `prod_mant` is always 0.
- R4: `prod_exp` equals `mcand_exp + mplier_exp` modulo 2^EXP_W, plus one when the R3 shift occurs.
- R5: An all-zero multiplier word other than the top word takes exactly one cycle. After that cycle, the top word of the accumulator is zero.
- R6: `busy` stays high for a number of cycles equal to the sum of the following, plus one normalisation cycle:
  - word 0, if nonzero: `WORD_W-NG` cycles;
  - each other nonzero word below the top: `WORD_W` cycles;
  - the top word: (index of its highest set bit + 1) cycles;
  - each zero word below the top: 1 cycle.
- R7: `done` is a single-cycle pulse that coincides with `busy` being low. `busy` rises in the cycle after `start` is sampled.
- R8: A `start` asserted while `busy` is high is ignored. The running operation's result and duration are unchanged.
- R9: `prod_mant`, `prod_exp` and `prod_sticky` stay stable from one `done` until the next.
- R10: After reset, `busy`, `done` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation; sampled only while idle |
| mcand_mant | input | NWORDS*WORD_W | Multiplicand mantissa X |
| mplier_mant | input | NWORDS*WORD_W | Multiplier mantissa Y, scanned low word first |
| mcand_exp | input | EXP_W | Multiplicand exponent |
| mplier_exp | input | EXP_W | Multiplier exponent |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: new result valid |
| prod_mant | output | NWORDS*WORD_W | Normalised product mantissa |
| prod_exp | output | EXP_W | Exponent sum with normalisation increment |
| prod_sticky | output | 1 | OR of every product bit discarded |

## Verification
On every cycle, the assertions check the following:
- no add carries out of the accumulator;
- a word skip leaves the accumulator's top word clear;
- the sticky flag never drops mid-operation;
- the normalised result never has bit `LEAD+1` set;
- `done` is a lone pulse that comes with `busy` low;
- the result outputs hold still while the block is idle.

The numerical correctness of the mantissa, sticky flag and exponent can only be shown by the bench's directed scenarios, which compare against a double-width product. The same is true of the exact cycle counts for skipped, partial and top words, and of the rejection of a `start` issued mid-operation.

// File: rtl/msm_pkg.sv
package msm_pkg;
  // Action the accumulator performs in a given cycle
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STEP  = 3'd2,
    OP_WSKIP = 3'd3,
    OP_NORM  = 3'd4
  } msm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NORM = 2'd2
  } msm_state_e;
endpackage

// File: rtl/msm_word_pick.sv
module msm_word_pick #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int NG     = 2,
  localparam int MANT_W = WORD_W * NWORDS,
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int BIDX_W = $clog2(WORD_W)
) (
  input  logic [MANT_W-1:0] y_word_src,
  input  logic [WIDX_W-1:0] w_idx,
  input  logic [BIDX_W-1:0] b_idx,
  output logic              ybit,
  output logic              word_zero,
  output logic              at_first,
  output logic              is_top,
  output logic              last_bit
);
  localparam int SH_W = BIDX_W + 1;

  logic [WORD_W-1:0] words [NWORDS];
  logic [WORD_W-1:0] cur;
  logic [WORD_W-1:0] above;
  logic [BIDX_W-1:0] first_b;

  // Split the multiplier into its words, word 0 least significant
  for (genvar g = 0; g < NWORDS; g++) begin : g_split
    assign words[g] = y_word_src[g*WORD_W +: WORD_W];
  end

  assign cur       = words[w_idx];
  assign ybit      = cur[b_idx];
  assign word_zero = (cur == '0);
  assign is_top    = (w_idx == WIDX_W'(NWORDS-1));
  assign first_b   = (w_idx == '0) ? BIDX_W'(NG) : '0;
  assign at_first  = (b_idx == first_b);
  assign above     = cur >> (SH_W'(b_idx) + SH_W'(1));
  assign last_bit  = is_top ? (above == '0) : (b_idx == BIDX_W'(WORD_W-1));
endmodule

// File: rtl/msm_ctrl.sv
module msm_ctrl
  import msm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int NG     = 2,
  localparam int MANT_W = WORD_W * NWORDS,
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int BIDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MANT_W-1:0] y_in,
  input  logic              ybit,
  input  logic              word_zero,
  input  logic              at_first,
  input  logic              is_top,
  input  logic              last_bit,
  output logic [MANT_W-1:0] y_hold,
  output logic [WIDX_W-1:0] w_idx,
  output logic [BIDX_W-1:0] b_idx,
  output msm_op_e           op,
  output logic              busy,
  output logic              done
);
  msm_state_e state;
  logic       live;       // an add has happened, accumulator nonzero
  logic       skip_word;  // whole zero word consumed this cycle
  logic       step_now;   // one multiplier bit consumed this cycle

  assign skip_word = (state == ST_RUN) && at_first && word_zero && !is_top;
  assign step_now  = (state == ST_RUN) && !skip_word;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    op = OP_HOLD;
    unique case (state)
      ST_IDLE: if (start) op = OP_LOAD;
      ST_RUN:  begin
        if (skip_word) op = live ? OP_WSKIP : OP_HOLD;
        else           op = OP_STEP;
      end
      ST_NORM: op = OP_NORM;
      default: op = OP_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      y_hold <= '0;
      w_idx  <= '0;
      b_idx  <= '0;
      live   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          y_hold <= y_in;
          w_idx  <= '0;
          b_idx  <= BIDX_W'(NG);
          live   <= 1'b0;
          state  <= ST_RUN;
        end
        ST_RUN: begin
          if (skip_word) begin
            w_idx <= w_idx + WIDX_W'(1);
            b_idx <= '0;
          end else if (step_now) begin
            live <= live | ybit;
            if (last_bit) begin
              if (is_top) state <= ST_NORM;
              else begin
                w_idx <= w_idx + WIDX_W'(1);
                b_idx <= '0;
              end
            end else begin
              b_idx <= b_idx + BIDX_W'(1);
            end
          end
        end
        ST_NORM: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  run_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> busy);
endmodule

// File: rtl/msm_accum.sv
module msm_accum
  import msm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int LEAD   = 114,
  parameter int EXP_W  = 16,
  localparam int MANT_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  msm_op_e           op,
  input  logic              ybit,
  input  logic [MANT_W-1:0] x_in,
  input  logic [EXP_W-1:0]  ea,
  input  logic [EXP_W-1:0]  eb,
  output logic [MANT_W-1:0] res_mant,
  output logic [EXP_W-1:0]  res_exp,
  output logic              res_sticky
);
  logic [MANT_W-1:0] x_r;
  logic [MANT_W-1:0] acc;
  logic              stk;
  logic [EXP_W-1:0]  exp_r;

  // Shift right one, then add X when the multiplier bit is set
  function automatic logic [MANT_W:0] shift_add(input logic [MANT_W-1:0] a,
                                                input logic [MANT_W-1:0] x,
                                                input logic en);
    logic [MANT_W:0] addend;
    addend = en ? {1'b0, x} : '0;
    return {1'b0, (a >> 1)} + addend;
  endfunction

  logic [MANT_W:0] step_sum;
  logic            step_carry;  // would overflow the accumulator
  logic            need_norm;   // raw product is at least 2.0
  logic            skip_drop;   // low word lost by a word skip

  assign step_sum   = shift_add(acc, x_r, ybit);
  assign step_carry = step_sum[MANT_W];
  assign need_norm  = acc[LEAD+1];
  assign skip_drop  = |acc[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_r        <= '0;
      acc        <= '0;
      stk        <= 1'b0;
      exp_r      <= '0;
      res_mant   <= '0;
      res_exp    <= '0;
      res_sticky <= 1'b0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          x_r   <= x_in;
          acc   <= '0;
          stk   <= 1'b0;
          exp_r <= ea + eb;
        end
        OP_STEP: begin
          stk <= stk | acc[0];
          acc <= step_sum[MANT_W-1:0];
        end
        OP_WSKIP: begin
          stk <= stk | skip_drop;
          acc <= acc >> WORD_W;
        end
        OP_NORM: begin
          if (need_norm) begin
            res_mant   <= acc >> 1;
            res_sticky <= stk | acc[0];
            res_exp    <= exp_r + EXP_W'(1);
          end else begin
            res_mant   <= acc;
            res_sticky <= stk;
            res_exp    <= exp_r;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  acc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |-> !step_carry);
  // R5
  wskip_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WSKIP) |=> (acc[MANT_W-1 -: WORD_W] == '0));
  // R2
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk && op != OP_LOAD) |=> stk);
  // R3
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NORM) |=> !res_mant[LEAD+1]);
endmodule

// File: rtl/mant_shift_mul.sv
module mant_shift_mul
  import msm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int NG     = 2,
  parameter int LEAD   = 114,
  parameter int EXP_W  = 16,
  localparam int MANT_W = WORD_W * NWORDS,
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int BIDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MANT_W-1:0] mcand_mant,
  input  logic [MANT_W-1:0] mplier_mant,
  input  logic [EXP_W-1:0]  mcand_exp,
  input  logic [EXP_W-1:0]  mplier_exp,
  output logic              busy,
  output logic              done,
  output logic [MANT_W-1:0] prod_mant,
  output logic [EXP_W-1:0]  prod_exp,
  output logic              prod_sticky
);
  msm_op_e           op;
  logic [MANT_W-1:0] y_hold;
  logic [WIDX_W-1:0] w_idx;
  logic [BIDX_W-1:0] b_idx;
  logic              ybit, word_zero, at_first, is_top, last_bit;

  msm_ctrl #(.WORD_W(WORD_W), .NWORDS(NWORDS), .NG(NG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .y_in(mplier_mant),
    .ybit(ybit), .word_zero(word_zero), .at_first(at_first),
    .is_top(is_top), .last_bit(last_bit), .y_hold(y_hold),
    .w_idx(w_idx), .b_idx(b_idx), .op(op), .busy(busy), .done(done)
  );

  msm_word_pick #(.WORD_W(WORD_W), .NWORDS(NWORDS), .NG(NG)) u_pick (
    .y_word_src(y_hold), .w_idx(w_idx), .b_idx(b_idx), .ybit(ybit),
    .word_zero(word_zero), .at_first(at_first), .is_top(is_top),
    .last_bit(last_bit)
  );

  msm_accum #(.WORD_W(WORD_W), .NWORDS(NWORDS), .LEAD(LEAD), .EXP_W(EXP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .op(op), .ybit(ybit), .x_in(mcand_mant),
    .ea(mcand_exp), .eb(mplier_exp), .res_mant(prod_mant),
    .res_exp(prod_exp), .res_sticky(prod_sticky)
  );

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(prod_mant) && $stable(prod_exp) && $stable(prod_sticky)));
endmodule

// File: tb/mant_shift_mul_bench.sv
module mant_shift_mul_bench;
  localparam int WW = 32;
  localparam int NW = 4;
  localparam int NG = 2;
  localparam int L  = 114;
  localparam int EW = 16;
  localparam int MW = WW * NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] mcand_mant = '0, mplier_mant = '0;
  logic [EW-1:0] mcand_exp = '0, mplier_exp = '0;
  logic          busy, done, prod_sticky;
  logic [MW-1:0] prod_mant;
  logic [EW-1:0] prod_exp;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mant_shift_mul u_mant_shift_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand_mant(mcand_mant),
    .mplier_mant(mplier_mant), .mcand_exp(mcand_exp), .mplier_exp(mplier_exp),
    .busy(busy), .done(done), .prod_mant(prod_mant), .prod_exp(prod_exp),
    .prod_sticky(prod_sticky)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [MW-1:0] act, input logic [MW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Expected busy cycles, from the multiplier words alone (R6)
  function automatic int exp_lat(input logic [MW-1:0] y);
    int n = 0;
    int hi = 0;
    logic [WW-1:0] t;
    for (int w = 0; w < NW-1; w++) begin
      logic [WW-1:0] m;
      m = y[w*WW +: WW];
      if (m == '0) n += 1;
      else n += (w == 0) ? WW - NG : WW;
    end
    t = y[(NW-1)*WW +: WW];
    for (int b = 0; b < WW; b++) if (t[b]) hi = b + 1;
    return n + hi + 1;
  endfunction

  function automatic logic [MW-1:0] rnd_mant(input bit is_mplier);
    logic [MW-1:0] v;
    for (int w = 0; w < NW; w++) v[w*WW +: WW] = $urandom;
    v = v & ((MW'(1) << (L+1)) - 1);
    v[L] = 1'b1;
    if (is_mplier) v[NG-1:0] = '0;
    return v;
  endfunction

  task automatic run_op(input logic [MW-1:0] x, input logic [MW-1:0] y,
                        input logic [EW-1:0] ea, input logic [EW-1:0] eb,
                        input bit inject, input string tag);
    logic [2*MW-1:0] p;
    logic [2*MW-1:0] a;
    logic            stk;
    logic [EW-1:0]   e;
    int              cnt, lat, guard;
    p   = {{MW{1'b0}}, x} * {{MW{1'b0}}, y};
    a   = p >> L;
    stk = |(p & (((2*MW)'(1) << L) - 1));
    e   = ea + eb;
    if (a[L+1]) begin
      stk = stk | a[0];
      a   = a >> 1;
      e   = e + EW'(1);
    end
    lat = exp_lat(y);

    @(negedge clk);
    mcand_mant = x; mplier_mant = y; mcand_exp = ea; mplier_exp = eb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0; guard = 0;
    while (!done && guard < 2000) begin
      if (busy) cnt++;
      if (inject && cnt == 3) begin
        start = 1'b1;
        mcand_mant = ~x; mplier_mant = rnd_mant(1'b1);
        mcand_exp = ~ea; mplier_exp = ~eb;
      end else start = 1'b0;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1, "R7", {tag, " done seen"}, MW'(done), MW'(1));
    chk(prod_mant == a[MW-1:0], "R1", {tag, " mantissa"}, prod_mant, a[MW-1:0]);
    chk(prod_sticky == stk, "R2", {tag, " sticky"}, MW'(prod_sticky), MW'(stk));
    chk(prod_exp == e, "R4", {tag, " exponent"}, MW'(prod_exp), MW'(e));
    chk(cnt == lat, inject ? "R8" : "R6", {tag, " busy cycles"}, MW'(cnt), MW'(lat));
    @(negedge clk);
    chk(!done && !busy, "R7", {tag, " done single pulse"}, MW'({busy, done}), MW'(0));
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R10", "reset busy/done", MW'({busy, done}), MW'(0));
    chk(prod_mant == '0 && prod_exp == '0 && !prod_sticky, "R10",
        "reset result", prod_mant, '0);
  endtask

  task automatic t_unit();
    run_op(MW'(1) << L, MW'(1) << L, 16'h0010, 16'h0005, 1'b0, "unit");
  endtask

  task automatic t_max_norm();
    logic [MW-1:0] xm, ym;
    xm = (MW'(1) << (L+1)) - 1;
    ym = xm & ~MW'((1 << NG) - 1);
    // R3: product near 4.0 needs the extra shift
    run_op(xm, ym, 16'h7ff0, 16'h0020, 1'b0, "max R3");
  endtask

  task automatic t_sticky();
    run_op((MW'(1) << L) | MW'(1), (MW'(1) << L) | (MW'(1) << NG),
           16'h0001, 16'hffff, 1'b0, "sticky R2");
  endtask

  task automatic t_mid_zero();
    // R5: word 1 zero while the accumulator already holds data
    run_op(rnd_mant(1'b0), (MW'(1) << L) | (MW'(1) << 70) | (MW'(1) << 5),
           16'h0100, 16'h0200, 1'b0, "midzero R5");
  endtask

  task automatic t_busy_start();
    run_op(rnd_mant(1'b0), rnd_mant(1'b1), 16'h0033, 16'h0044, 1'b1, "inject R8");
  endtask

  task automatic t_hold();
    logic [MW-1:0] m0;
    logic [EW-1:0] e0;
    logic          s0;
    bit            same = 1'b1;
    m0 = prod_mant; e0 = prod_exp; s0 = prod_sticky;
    mcand_mant = ~mcand_mant; mplier_mant = rnd_mant(1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (prod_mant != m0 || prod_exp != e0 || prod_sticky != s0) same = 1'b0;
    end
    chk(same, "R9", "outputs held while idle", prod_mant, m0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 6; i++) begin
      logic [MW-1:0] y;
      y = rnd_mant(1'b1);
      if (i % 2 == 0) y[WW +: WW] = '0;
      if (i % 3 == 0) y[2*WW +: WW] = '0;
      if (i == 4) y[WW-1:0] = '0;
      run_op(rnd_mant(1'b0), y, EW'($urandom), EW'($urandom), 1'b0, "random R1");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unit();
    t_max_norm();
    t_sticky();
    t_mid_zero();
    t_busy_start();
    t_hold();
    t_random();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule